// File: doc/BRIEF.md
# External Clock Edge Conditioner

This block takes a free-running, asynchronous signal from an input pin and turns it into single-cycle count-enable strobes in the timer clock domain. A timer counter that would otherwise advance on every timer clock advances instead on each strobe, so the counter runs at the rate of the external signal. A timer clock must be faster than the pin signal for this to work.

The pin is first brought into the timer domain through a short flip-flop chain. An optional inversion follows, so either rising or falling pin edges can be counted. A digital glitch filter comes next. It moves its output level only after the input has held a new level for a programmed number of consecutive clocks. The last stage is an edge detector with a power-of-two prescaler, which emits one strobe for every 1, 2, 4 or 8 qualifying edges. Every stage is registered, so the path from a pin edge to a strobe has a fixed latency.

Top module: `extclk_conditioner`

## Requirements
- R1: While `rst` is high, `cnt_en_o` is 0. A synchronous reset clears the synchronizer, the filter count, the filtered level, the previous-level register and the prescaler count. If the pin is held low after reset with `invert_i`=0, no strobe occurs, even when the filtered level was high before the reset.
- R2: With `filt_code_i`=0 and `div_code_i`=0, a rising pin transition that first meets the synchronizer at clock edge 1 raises `cnt_en_o` right after clock edge 4.
- R3: With `invert_i`=0, only rising pin transitions count. With `invert_i`=1, the synchronized pin is complemented before the filter, so only falling pin transitions count.
- R4: With `filt_code_i`=0, the filter passes the synchronized level through with one register of delay, so a pin pulse one clock wide is counted.
- R5: With `filt_code_i`=k (1 to 15), the filtered level follows a new input level only after N=2k consecutive samples at that level. A high pulse N clocks wide is counted, and one N-1 clocks wide is discarded. The strobe appears after clock edge 3+N.
- R6: With `div_code_i`=d, one strobe is issued on every 2^d-th rising edge of the filtered level, starting with the 2^d-th edge after reset.
- R7: A change of `div_code_i` clears the prescaler count. An edge that arrives in the same clock as the change is dropped.
- R8: `cnt_en_o` is never high for two clocks in a row.
- R9: A filter count that has not finished restarts from zero whenever the input goes back to the filtered level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_pin_i | input | 1 | Asynchronous external clock pin |
| invert_i | input | 1 | 1 = count falling pin transitions |
| filt_code_i | input | FILT_W | Filter length code, 0 = bypass |
| div_code_i | input | DIV_W | Prescaler code, ratio 2^code |
| cnt_en_o | output | 1 | One-clock count-enable strobe |

## Verification
A pin change driven at a falling clock edge reaches the filter input after two rising edges. The strobe is then due right after rising edge 3+N, where N is 1 for the bypass code and 2k otherwise. The bench counts falling edges from the pin change and requires the first strobe at exactly that count. Pulse trains and glitches are scored by counting strobes at falling edges over a drain window of 40 clocks, which is longer than the worst latency of 33. Every configuration change is made while the input is idle, except in the prescaler-clear test, where the change falls between counted edges.

// File: rtl/extclk_pkg.sv
package extclk_pkg;

  // Number of consecutive samples the filter needs for a given code.
  function automatic int unsigned filt_samples(input int unsigned code);
    return (code == 0) ? 1 : 2 * code;
  endfunction

endpackage

// File: rtl/extclk_sync.sv
module extclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic invert_i,
  output logic lvl_o
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign lvl_o = chain_q[STAGES-1] ^ invert_i;

endmodule

// File: rtl/extclk_filter.sv
module extclk_filter #(
  parameter int FILT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FILT_W-1:0] code_i,
  input  logic              lvl_i,
  output logic              lvl_o
);

  localparam int MAXN  = 2 * ((1 << FILT_W) - 1);
  localparam int CNT_W = $clog2(MAXN + 1);

  logic [CNT_W-1:0] need_m1;
  logic [CNT_W-1:0] cnt_q;
  logic             lvl_q;

  always_comb begin
    need_m1 = CNT_W'(extclk_pkg::filt_samples(int'(code_i)) - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (lvl_i == lvl_q) begin
      cnt_q <= '0;
    end else if (cnt_q >= need_m1) begin
      lvl_q <= lvl_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lvl_o = lvl_q;

  // R5
  filt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lvl_i == lvl_q) |=> $stable(lvl_q));

  // R5
  filt_move_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(lvl_q)) |-> $past(cnt_q >= need_m1));

  // R9
  filt_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (lvl_i == lvl_q) |=> (cnt_q == '0));

  // R5
  filt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CNT_W'(MAXN));

endmodule

// File: rtl/extclk_edge_div.sv
module extclk_edge_div #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] code_i,
  input  logic             lvl_i,
  output logic             cen_o
);

  localparam int CNT_W = (1 << DIV_W) - 1;

  logic             prev_q;
  logic [DIV_W-1:0] code_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             cen_q;
  logic             rise;

  always_comb begin
    lim  = CNT_W'((1 << code_i) - 1);
    rise = lvl_i & ~prev_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      code_q <= '0;
      cnt_q  <= '0;
      cen_q  <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      code_q <= code_i;
      cen_q  <= 1'b0;
      if (code_i != code_q) begin
        cnt_q <= '0;
      end else if (rise) begin
        if (cnt_q >= lim) begin
          cnt_q <= '0;
          cen_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign cen_o = cen_q;

  // R8
  cen_single_chk: assert property (@(posedge clk) disable iff (rst)
    cen_q |=> !cen_q);

  // R6
  div_range_chk: assert property (@(posedge clk) disable iff (rst)
    (code_i == code_q) |-> (cnt_q <= lim));

  // R7
  div_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (code_i != code_q) |=> (cnt_q == '0 && !cen_q));

  // R6
  cen_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cen_q) |-> $past(lvl_i && !prev_q));

endmodule

// File: rtl/extclk_conditioner.sv
module extclk_conditioner #(
  parameter int FILT_W      = 4,
  parameter int DIV_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_pin_i,
  input  logic              invert_i,
  input  logic [FILT_W-1:0] filt_code_i,
  input  logic [DIV_W-1:0]  div_code_i,
  output logic              cnt_en_o
);

  logic sync_lvl;
  logic filt_lvl;

  extclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .pin_i    (ext_pin_i),
    .invert_i (invert_i),
    .lvl_o    (sync_lvl)
  );

  extclk_filter #(.FILT_W(FILT_W)) u_filter (
    .clk    (clk),
    .rst    (rst),
    .code_i (filt_code_i),
    .lvl_i  (sync_lvl),
    .lvl_o  (filt_lvl)
  );

  extclk_edge_div #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst    (rst),
    .code_i (div_code_i),
    .lvl_i  (filt_lvl),
    .cen_o  (cnt_en_o)
  );

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> !cnt_en_o);

endmodule

// File: tb/test_extclk_conditioner.sv
module test_extclk_conditioner;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin = 1'b0;
  logic       inv = 1'b0;
  logic [3:0] fcode = '0;
  logic [1:0] dcode = '0;
  logic       cen;

  int checks = 0;
  int errs   = 0;
  int pulses = 0;
  int dbl    = 0;
  bit prev_cen = 1'b0;

  extclk_conditioner i_extclk_conditioner (
    .clk         (clk),
    .rst         (rst),
    .ext_pin_i   (pin),
    .invert_i    (inv),
    .filt_code_i (fcode),
    .div_code_i  (dcode),
    .cnt_en_o    (cen)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (cen) begin
      pulses++;
      if (prev_cen) dbl++;
    end
    prev_cen = cen;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    wait_n(3);
    rst = 1'b0;
    wait_n(3);
    pulses = 0;
  endtask

  function automatic int nsamp(input int k);
    return (k == 0) ? 1 : 2 * k;
  endfunction

  // Train of k_pulses high pulses, each w clocks wide with w clocks low between.
  task automatic train(input int w, input int k_pulses);
    for (int p = 0; p < k_pulses; p++) begin
      pin = 1'b1;
      wait_n(w);
      pin = 1'b0;
      wait_n(w);
    end
    wait_n(40);
  endtask

  task automatic latency(input string req, input bit level, input int exp);
    int first;
    first = 0;
    pin = level;
    for (int i = 1; i <= 45; i++) begin
      @(negedge clk);
      if (cen && first == 0) first = i;
    end
    check(first == exp, req, first, exp);
  endtask

  initial begin
    rst = 1'b1;
    wait_n(4);

    // R1: reset state, quiet during reset with pin high
    pin = 1'b1;
    wait_n(40);
    pulses = 0;
    rst = 1'b1;
    wait_n(4);
    check(cen == 1'b0, "R1 output low in reset", int'(cen), 0);
    pin = 1'b0;
    rst = 1'b0;
    wait_n(40);
    check(pulses == 0, "R1 no strobe after reset clears level", pulses, 0);

    // R2 / R5: latency per filter code
    for (int k = 0; k < 16; k++) begin
      fcode = 4'(k);
      dcode = 2'd0;
      pin = 1'b0;
      do_reset();
      latency((k == 0) ? "R2 bypass latency" : "R5 filtered latency", 1'b1, 3 + nsamp(k));
      pin = 1'b0;
      wait_n(40);
    end

    // R3: inverted polarity counts falling transitions only
    inv = 1'b1;
    fcode = 4'd0;
    dcode = 2'd0;
    pin = 1'b1;
    do_reset();
    wait_n(10);
    check(pulses == 0, "R3 idle high with inversion", pulses, 0);
    latency("R3 falling edge counted", 1'b0, 4);
    pulses = 0;
    pin = 1'b1;
    wait_n(20);
    check(pulses == 0, "R3 rising edge ignored when inverted", pulses, 0);
    inv = 1'b0;
    pin = 1'b0;
    do_reset();
    pin = 1'b1;
    wait_n(20);
    pulses = 0;
    pin = 1'b0;
    wait_n(20);
    check(pulses == 0, "R3 falling edge ignored when not inverted", pulses, 0);

    // R4 / R5 / R6: sweep filter and prescaler codes with trains at width N
    for (int k = 0; k < 16; k++) begin
      for (int d = 0; d < 4; d++) begin
        fcode = 4'(k);
        dcode = 2'(d);
        pin = 1'b0;
        do_reset();
        train(nsamp(k), 8);
        check(pulses == (8 >> d),
              (k == 0) ? "R4 R6 bypass train" : "R5 R6 filtered train",
              pulses, 8 >> d);
      end
    end

    // R5 / R9: glitches one clock shorter than N are discarded
    for (int k = 1; k < 16; k++) begin
      fcode = 4'(k);
      dcode = 2'd0;
      pin = 1'b0;
      do_reset();
      for (int p = 0; p < 6; p++) begin
        pin = 1'b1;
        wait_n(nsamp(k) - 1);
        pin = 1'b0;
        wait_n(nsamp(k));
      end
      wait_n(40);
      check(pulses == 0, "R5 R9 short glitch discarded", pulses, 0);
    end

    // R7: prescaler count cleared on code change
    fcode = 4'd0;
    dcode = 2'd1;
    pin = 1'b0;
    do_reset();
    train(2, 1);
    check(pulses == 0, "R7 one edge at ratio 2", pulses, 0);
    dcode = 2'd2;
    wait_n(4);
    train(2, 3);
    check(pulses == 0, "R7 three edges after change to ratio 4", pulses, 0);
    train(2, 1);
    check(pulses == 1, "R7 fourth edge after change", pulses, 1);

    // R8: never two consecutive strobe clocks
    check(dbl == 0, "R8 single-clock strobe", dbl, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule